// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a shared two-port memory and turns the two top words of that memory into doorbells between the ports. It watches each port's select, write strobe, output enable and address. A write by one port into the other port's mailbox word raises an active-low interrupt toward the other port. That interrupt stays low until its owner reads its own mailbox word. The message itself is held in the ordinary memory array, which is not part of this block.

Each port also receives a hold input from the contention arbiter, which is outside this block. While a port's hold is high, that port's accesses can neither raise the other side's interrupt nor clear its own. Accesses are sampled on the rising clock edge. The interrupt outputs are registered, so they change one cycle after the qualifying access.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both `l_irq_n` and `r_irq_n` are 1 (deasserted).
- R2: A left access with `l_sel`=1, `l_wr`=1, `l_hold`=0 and `l_addr` equal to the all-ones address drives `r_irq_n` to 0 on the next cycle.
- R3: A right access with `r_sel`=1, `r_wr`=1, `r_hold`=0 and `r_addr` equal to all-ones minus one drives `l_irq_n` to 0 on the next cycle.
- R4: A port clears its own interrupt to 1 on the next cycle by reading its own mailbox (`sel`=1, `wr`=0, `oe`=1, `hold`=0). The right mailbox is the all-ones address and the left mailbox is all-ones minus one.
- R5: A read of the other port's mailbox leaves both interrupts unchanged.
- R6: While a port's `hold` is 1, its write to the other port's mailbox does not assert the other port's interrupt.
- R7: While a port's `hold` is 1, its read of its own mailbox does not clear its interrupt.
- R8: When the same interrupt is set and cleared in the same cycle, it ends up asserted (0).
- R9: These accesses change neither interrupt: accesses with `sel`=0, reads with `oe`=0, writes to a port's own mailbox, and accesses to any address other than the two mailboxes.
- R10: The two mailbox addresses come from the `ADDR_W` parameter as all-ones and all-ones minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port memory select, active high |
| l_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable, active high |
| l_addr | input | ADDR_W | Left port address |
| l_hold | input | 1 | Arbiter hold toward the left port, active high |
| r_sel | input | 1 | Right port memory select, active high |
| r_wr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right port output enable, active high |
| r_addr | input | ADDR_W | Right port address |
| r_hold | input | 1 | Arbiter hold toward the right port, active high |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The bench builds the block with `ADDR_W` = 5. The mailboxes then sit at 31 and 30, and the bench also drives the neighbouring address 29 and address 0. With this small width, the same decode drives both the mailbox words and the words just below them, so a compare that is off by one bit shows up. The bench drives both ports in the same cycle to reach simultaneous set and clear, simultaneous set on both sides, and a hold that blocks only one side.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Decoded mailbox events for one port in one cycle
    typedef struct packed {
        logic post;   // write into the peer's mailbox
        logic take;   // read of the port's own mailbox
    } mbx_evt_t;

    // Registered interrupt state, active low
    typedef struct packed {
        logic l_irq_n;
        logic r_irq_n;
    } mbx_state_t;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter bit          IS_RIGHT = 1'b0
) (
    input  logic              sel,
    input  logic              wr,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hold,
    output mbx_evt_t          evt
);
    // R10: mailbox words derived from the address width
    localparam logic [ADDR_W-1:0] TOP_WORD  = '1;
    localparam logic [ADDR_W-1:0] NEXT_WORD = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic [ADDR_W-1:0] own_box;
    logic [ADDR_W-1:0] peer_box;

    generate
        if (IS_RIGHT) begin : g_right
            assign own_box  = TOP_WORD;
            assign peer_box = NEXT_WORD;
        end else begin : g_left
            assign own_box  = NEXT_WORD;
            assign peer_box = TOP_WORD;
        end
    endgenerate

    logic live;
    assign live = sel && !hold;

    always_comb begin
        evt      = '0;
        evt.post = live && wr && (addr == peer_box);
        evt.take = live && !wr && oe && (addr == own_box);
    end

endmodule

// File: rtl/mbx_irq_core.sv
module mbx_irq_core
    import mbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mbx_evt_t l_evt,
    input  mbx_evt_t r_evt,
    output logic     l_irq_n,
    output logic     r_irq_n
);
    mbx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clears first, sets afterwards: set wins (R8)
        if (l_evt.take) st_d.l_irq_n = 1'b1;
        if (r_evt.take) st_d.r_irq_n = 1'b1;
        if (r_evt.post) st_d.l_irq_n = 1'b0;
        if (l_evt.post) st_d.r_irq_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{l_irq_n: 1'b1, r_irq_n: 1'b1};
        else        st_q <= st_d;
    end

    assign l_irq_n = st_q.l_irq_n;
    assign r_irq_n = st_q.r_irq_n;

    // R2 R3 R8
    // a post always leaves the peer's interrupt asserted
    post_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_evt.post |=> !l_irq_n);
    post_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_evt.post |=> !r_irq_n);

    // R4
    take_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_evt.take && !r_evt.post) |=> l_irq_n);
    take_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_evt.take && !l_evt.post) |=> r_irq_n);

    // R5 R9
    // with no event, the interrupt holds its value
    quiet_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_evt.take && !r_evt.post) |=> $stable(l_irq_n));
    quiet_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_evt.take && !l_evt.post) |=> $stable(r_irq_n));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_hold,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_hold,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    mbx_evt_t l_evt, r_evt;

    mbx_port_decode #(.ADDR_W(ADDR_W), .IS_RIGHT(1'b0)) u_dec_l (
        .sel(l_sel), .wr(l_wr), .oe(l_oe), .addr(l_addr), .hold(l_hold), .evt(l_evt)
    );

    mbx_port_decode #(.ADDR_W(ADDR_W), .IS_RIGHT(1'b1)) u_dec_r (
        .sel(r_sel), .wr(r_wr), .oe(r_oe), .addr(r_addr), .hold(r_hold), .evt(r_evt)
    );

    mbx_irq_core u_core (
        .clk(clk), .rst_n(rst_n), .l_evt(l_evt), .r_evt(r_evt),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // R6
    // only the left port raises the right interrupt, so a left hold keeps it idle
    hold_blocks_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && l_hold) |=> r_irq_n);

    // R7
    // only the right port clears its own interrupt, so a right hold keeps it asserted
    hold_blocks_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_irq_n && r_hold) |=> !r_irq_n);

    // R6 R7 (left side)
    hold_left_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && r_hold) |=> l_irq_n);

endmodule

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;
    localparam int unsigned AW     = 5;
    localparam time         PERIOD = 10ns;
    localparam logic [AW-1:0] TOPW  = 5'd31;
    localparam logic [AW-1:0] NEXTW = 5'd30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel = 0, l_wr = 0, l_oe = 0, l_hold = 0;
    logic r_sel = 0, r_wr = 0, r_oe = 0, r_hold = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic l;
        logic r;
        int   req;
    } exp_t;
    exp_t sb[$];

    logic exp_l = 1'b1, exp_r = 1'b1;

    always #(PERIOD/2) clk = ~clk;

    mbx_irq_ctrl #(.ADDR_W(AW)) i_mbx_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_hold(l_hold),
        .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_hold(r_hold),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    task automatic compare(input logic gl, input logic gr, input int req);
        checks++;
        if (l_irq_n !== gl || r_irq_n !== gr) begin
            errors++;
            $display("FAIL R%0d: got l=%b r=%b expected l=%b r=%b", req, l_irq_n, r_irq_n, gl, gr);
        end
    endtask

    // monitor: pops one expected item per cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.l, e.r, e.req);
        end
    end

    // driver: one cycle of stimulus on both ports, expected result from the rules
    task automatic step(input logic ls, input logic lw, input logic lo, input logic [AW-1:0] la,
                        input logic lh, input logic rs, input logic rw, input logic ro,
                        input logic [AW-1:0] ra, input logic rh, input int req);
        logic l_sets_r, l_clears_l, r_sets_l, r_clears_r;
        exp_t e;
        @(negedge clk);
        l_sel = ls; l_wr = lw; l_oe = lo; l_addr = la; l_hold = lh;
        r_sel = rs; r_wr = rw; r_oe = ro; r_addr = ra; r_hold = rh;
        l_sets_r   = ls && !lh && lw && la == TOPW;
        l_clears_l = ls && !lh && !lw && lo && la == NEXTW;
        r_sets_l   = rs && !rh && rw && ra == NEXTW;
        r_clears_r = rs && !rh && !rw && ro && ra == TOPW;
        if (l_clears_l) exp_l = 1'b1;
        if (r_clears_r) exp_r = 1'b1;
        if (r_sets_l)   exp_l = 1'b0;
        if (l_sets_r)   exp_r = 1'b0;
        @(posedge clk);
        #1;
        e.l = exp_l; e.r = exp_r; e.req = req;
        sb.push_back(e);
    endtask

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 3);
        @(negedge clk);
        compare(1'b1, 1'b1, 1);                          // R1 during reset
        rst_n = 1'b1;
        step(0,0,0, 5'd0,  0, 0,0,0, 5'd0,  0, 1);       // R1 idle after reset
        step(1,1,0, TOPW,  0, 0,0,0, 5'd0,  0, 2);       // R2 left posts to right
        step(1,0,1, TOPW,  0, 0,0,0, 5'd0,  0, 5);       // R5 left reads right's box
        step(0,0,0, 5'd0,  0, 1,0,1, NEXTW, 0, 5);       // R5 right reads left's box
        step(0,0,0, 5'd0,  0, 1,0,0, TOPW,  0, 9);       // R9 read without oe
        step(0,0,0, 5'd0,  0, 1,0,1, TOPW,  1, 7);       // R7 held read
        step(0,0,0, 5'd0,  0, 1,0,1, TOPW,  0, 4);       // R4 right clears
        step(0,0,0, 5'd0,  0, 1,1,0, NEXTW, 1, 6);       // R6 held write
        step(0,0,0, 5'd0,  0, 1,1,0, NEXTW, 0, 3);       // R3 right posts to left
        step(1,1,0, 5'd0,  0, 1,1,0, 5'd29, 0, 10);      // R10 neighbour addresses
        step(1,1,0, NEXTW, 0, 1,1,0, TOPW,  0, 9);       // R9 writes to own box
        step(1,0,1, NEXTW, 1, 0,0,0, 5'd0,  0, 7);       // R7 left held read
        step(1,0,1, NEXTW, 0, 0,0,0, 5'd0,  0, 4);       // R4 left clears
        step(1,1,0, TOPW,  0, 1,0,1, TOPW,  0, 8);       // R8 set and clear together
        step(1,1,0, TOPW,  0, 1,1,0, NEXTW, 0, 2);       // R2 and R3 together
        step(1,0,1, NEXTW, 0, 1,0,1, TOPW,  0, 4);       // R4 both clear
        step(0,1,0, TOPW,  0, 0,1,0, NEXTW, 0, 9);       // R9 unselected writes
        step(1,1,0, TOPW,  1, 1,1,0, NEXTW, 0, 6);       // R6 only left held
        step(1,0,1, 5'd29, 0, 1,0,1, 5'd29, 0, 10);      // R10 reads below mailboxes
        step(0,0,0, 5'd0,  0, 0,0,0, 5'd0,  0, 9);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule